// File: doc/BRIEF.md
# Isochronous Double-Bank Transmit Flush Controller

This block manages the two banks of transmit storage that feed an isochronous IN pipe on the device side of a USB controller. The local CPU fills the banks one after the other, and the packet engine drains them in the same alternating order. A write pointer and a transmit pointer each flip on their own completion events. Each bank is always in one of four states: `BK_EMPTY`, `BK_WRITING`, `BK_LOADED` (fully written) or `BK_TXEN` (enabled for transmission).

Bank transitions:
- `BK_EMPTY`→`BK_WRITING` on a write start.
- `BK_WRITING`→`BK_LOADED` on a write done.
- `BK_LOADED`→`BK_TXEN` once the transmit pointer lands on the bank.
- `BK_TXEN`→`BK_EMPTY` when the bank is sent or flushed.
- Any state→`BK_EMPTY` when the pipe is disabled.

A frame monitor watches start-of-frame (SOF) pulses and IN-token pulses. Its states are `MON_OFF`, `MON_WAIT` and `MON_ON`, with these transitions:
- `MON_OFF`→`MON_WAIT` once the pipe is valid.
- `MON_WAIT`→`MON_ON` at the first SOF when the interval setting is zero, or after the first normal transaction when it is nonzero.
- Any state→`MON_OFF` when the pipe is disabled.

While the monitor is `MON_ON`, a service frame that closes without an IN token is handled as if its token had been corrupted. The transmission-enabled bank is flushed back to empty, and a loaded partner bank takes its place at the same clock edge.

Top module: `iso_tx_flush_ctrl`

## Requirements
- R1: After reset, both banks read `BK_EMPTY` (encoding: 0 empty, 1 writing, 2 loaded, 3 transmission-enabled; bank 0 in `bank_st_o[1:0]`, bank 1 in `bank_st_o[3:2]`), both pointers read 0 and `flush_o` is low.
- R2: `wr_start_i` moves the bank at the write pointer from empty to writing. It has no effect on a bank in any other state.
- R3: `wr_done_i` moves the bank at the write pointer from writing to loaded and flips the write pointer. It has no effect when that bank is not writing.
- R4: A loaded bank under the transmit pointer becomes transmission-enabled at the next clock edge. At most one bank is ever transmission-enabled.
- R5: `tx_done_i` on a transmission-enabled bank empties that bank and flips the transmit pointer. When the bank under the transmit pointer is not transmission-enabled, `tx_done_i` has no effect.
- R6: In the same cycle as `in_tok_i`, exactly one response output is high: `resp_data_o` if the bank under the transmit pointer is transmission-enabled, otherwise `resp_zlp_o`.
- R7: With interval setting 0, monitoring arms at the first SOF seen after the pipe becomes valid. The frame in which the pipe became valid is never flushed.
- R8: With a nonzero interval setting, no flush happens until a normal transaction (a `tx_done_i` on a transmission-enabled bank) has completed.
- R9: While armed, an SOF that closes a service frame in which no IN token arrived flushes the transmission-enabled bank. The bank empties, the transmit pointer flips, and `flush_o` is high for exactly the following cycle.
- R10: When a flush hits one bank while the other bank is loaded, the other bank becomes transmission-enabled at the same clock edge.
- R11: Service frames recur every 2^`intv_i` frames, counted from the arming point. A token arriving in any other frame does not prevent the next flush.
- R12: If a flush and `tx_done_i` fall in the same cycle, the flush takes priority: `flush_o` pulses and the bank ends up empty.
- R13: While `pipe_en_i` is low, both banks are forced empty, both pointers go to 0 and monitoring is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_en_i | input | 1 | Pipe valid; low clears the block |
| intv_i | input | IVW | Interval exponent; service period is 2^intv_i frames |
| sof_i | input | 1 | Start-of-frame pulse |
| in_tok_i | input | 1 | IN token received pulse |
| wr_start_i | input | 1 | CPU begins writing the bank at the write pointer |
| wr_done_i | input | 1 | CPU finished writing the bank at the write pointer |
| tx_done_i | input | 1 | Packet engine finished sending from the transmit bank |
| resp_data_o | output | 1 | Token answered with bank data |
| resp_zlp_o | output | 1 | Token answered with a zero-length packet |
| flush_o | output | 1 | One-cycle pulse after a flush |
| wr_ptr_o | output | 1 | Current write bank |
| tx_ptr_o | output | 1 | Current transmit bank |
| bank_st_o | output | 4 | Two-bit state per bank |

## Verification
The assertions check several rules on every cycle:
- Never more than one transmission-enabled bank.
- Exactly one response for each token.
- A transmission-enabled bank is only entered from the loaded state.
- The transmit pointer moves whenever a flush is reported, and a loaded partner bank is promoted in the same edge.
- The clear while the pipe is disabled.
- The event that armed the monitor matches the interval setting.

Other behaviours depend on a history of frames and tokens, and only the bench's scenarios can show them:
- The frame in which the pipe became valid is exempt from flushing.
- Tokens that arrive early do not count as service.
- The frame counting across a period of 2^`intv_i` frames.
- The flush/transmit-done priority.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

    localparam int NBANK = 2;

    typedef enum logic [1:0] {
        BK_EMPTY   = 2'd0,
        BK_WRITING = 2'd1,
        BK_LOADED  = 2'd2,
        BK_TXEN    = 2'd3
    } bank_st_e;

    typedef enum logic [1:0] {
        MON_OFF  = 2'd0,
        MON_WAIT = 2'd1,
        MON_ON   = 2'd2
    } mon_st_e;

endpackage

// File: rtl/iso_bank_fsm.sv
module iso_bank_fsm
    import iso_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_i,
    input  logic     begin_wr_i,
    input  logic     end_wr_i,
    input  logic     promote_i,
    input  logic     retire_i,
    output bank_st_e st_o
);

    bank_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BK_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = BK_EMPTY;
        end else begin
            unique case (st_q)
                BK_EMPTY:   if (begin_wr_i) st_d = BK_WRITING;
                BK_WRITING: if (end_wr_i)   st_d = BK_LOADED;
                BK_LOADED:  if (promote_i)  st_d = BK_TXEN;
                BK_TXEN:    if (retire_i)   st_d = BK_EMPTY;
            endcase
        end
    end

    assign st_o = st_q;

    // R2
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_EMPTY && !begin_wr_i) |=> st_q == BK_EMPTY);

    // R4
    txen_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_TXEN && $past(st_q) != BK_TXEN) |-> $past(st_q) == BK_LOADED);

    // R5
    txen_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_TXEN && retire_i) |=> st_q == BK_EMPTY);

endmodule

// File: rtl/iso_frame_mon.sv
module iso_frame_mon
    import iso_tx_pkg::*;
#(
    parameter int IVW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pipe_en_i,
    input  logic [IVW-1:0] intv_i,
    input  logic           sof_i,
    input  logic           in_tok_i,
    input  logic           norm_txn_i,
    input  logic           txen_i,
    output logic           flush_req_o,
    output logic           armed_o
);

    localparam int CW = (1 << IVW) - 1;

    mon_st_e        mon_q, mon_d;
    logic [CW-1:0]  cnt_q, cnt_d, cnt_nxt, per_mask;
    logic           tok_q, tok_d;

    assign per_mask = ~({CW{1'b1}} << intv_i);
    assign cnt_nxt  = (cnt_q + CW'(1)) & per_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= MON_OFF;
            cnt_q <= '0;
            tok_q <= 1'b0;
        end else begin
            mon_q <= mon_d;
            cnt_q <= cnt_d;
            tok_q <= tok_d;
        end
    end

    always_comb begin
        mon_d = mon_q;
        cnt_d = cnt_q;
        tok_d = tok_q;
        if (!pipe_en_i) begin
            mon_d = MON_OFF;
            cnt_d = '0;
            tok_d = 1'b0;
        end else begin
            unique case (mon_q)
                MON_OFF: begin
                    mon_d = MON_WAIT;
                    cnt_d = '0;
                    tok_d = 1'b0;
                end
                MON_WAIT: begin
                    if (intv_i == '0) begin
                        if (sof_i) begin
                            mon_d = MON_ON;
                            cnt_d = '0;
                            tok_d = in_tok_i;
                        end
                    end else if (norm_txn_i) begin
                        mon_d = MON_ON;
                        cnt_d = '0;
                        tok_d = 1'b1;
                    end
                end
                MON_ON: begin
                    if (sof_i) begin
                        cnt_d = cnt_nxt;
                        tok_d = in_tok_i && (cnt_nxt == '0);
                    end else if (in_tok_i && cnt_q == '0) begin
                        tok_d = 1'b1;
                    end
                end
                default: mon_d = MON_OFF;
            endcase
        end
    end

    always_comb begin
        armed_o     = (mon_q == MON_ON);
        flush_req_o = armed_o && sof_i && (cnt_q == '0) && !tok_q && txen_i;
    end

    // R7
    arm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(armed_o) && $past(intv_i) == '0) |-> $past(sof_i));

    // R8
    arm_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(armed_o) && $past(intv_i) != '0) |-> $past(norm_txn_i));

endmodule

// File: rtl/iso_tx_flush_ctrl.sv
module iso_tx_flush_ctrl
    import iso_tx_pkg::*;
#(
    parameter int IVW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe_en_i,
    input  logic [IVW-1:0]   intv_i,
    input  logic             sof_i,
    input  logic             in_tok_i,
    input  logic             wr_start_i,
    input  logic             wr_done_i,
    input  logic             tx_done_i,
    output logic             resp_data_o,
    output logic             resp_zlp_o,
    output logic             flush_o,
    output logic             wr_ptr_o,
    output logic             tx_ptr_o,
    output logic [2*NBANK-1:0] bank_st_o
);

    bank_st_e st [NBANK];
    logic wr_ptr_q, wr_ptr_d, tx_ptr_q, tx_ptr_d, flush_q;
    logic txen_cur, flush_req, norm_txn, retire, wr_adv, armed;

    assign txen_cur = (st[tx_ptr_q] == BK_TXEN);
    assign norm_txn = tx_done_i && txen_cur && !flush_req;
    assign retire   = flush_req || norm_txn;
    assign wr_adv   = wr_done_i && (st[wr_ptr_q] == BK_WRITING);
    assign tx_ptr_d = pipe_en_i ? (tx_ptr_q ^ retire) : 1'b0;
    assign wr_ptr_d = pipe_en_i ? (wr_ptr_q ^ wr_adv) : 1'b0;

    iso_frame_mon #(.IVW(IVW)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_en_i  (pipe_en_i),
        .intv_i     (intv_i),
        .sof_i      (sof_i),
        .in_tok_i   (in_tok_i),
        .norm_txn_i (norm_txn),
        .txen_i     (txen_cur),
        .flush_req_o(flush_req),
        .armed_o    (armed)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        iso_bank_fsm u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (!pipe_en_i),
            .begin_wr_i(wr_start_i && (wr_ptr_q == 1'(g))),
            .end_wr_i  (wr_done_i && (wr_ptr_q == 1'(g))),
            .promote_i (tx_ptr_d == 1'(g)),
            .retire_i  (retire && (tx_ptr_q == 1'(g))),
            .st_o      (st[g])
        );
        assign bank_st_o[2*g +: 2] = st[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= 1'b0;
            tx_ptr_q <= 1'b0;
            flush_q  <= 1'b0;
        end else begin
            wr_ptr_q <= wr_ptr_d;
            tx_ptr_q <= tx_ptr_d;
            flush_q  <= pipe_en_i && flush_req;
        end
    end

    always_comb begin
        resp_data_o = in_tok_i && txen_cur;
        resp_zlp_o  = in_tok_i && !txen_cur;
        flush_o     = flush_q;
        wr_ptr_o    = wr_ptr_q;
        tx_ptr_o    = tx_ptr_q;
    end

    // R4
    one_txen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st[0] == BK_TXEN && st[1] == BK_TXEN));

    // R6
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_tok_i |-> (resp_data_o != resp_zlp_o));

    // R9
    flush_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (tx_ptr_q != $past(tx_ptr_q)));

    // R10
    swap_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && $past(st[~tx_ptr_q] == BK_LOADED)) |-> st[tx_ptr_q] == BK_TXEN);

    // R13
    pipe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_en_i |=> (bank_st_o == '0 && !flush_o && !tx_ptr_o && !wr_ptr_o));

endmodule

// File: tb/sim_iso_tx_flush_ctrl.sv
`timescale 1ns/1ps
module sim_iso_tx_flush_ctrl;

    localparam int IVW = 2;
    localparam int CW  = (1 << IVW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pipe_en = 1'b0, sof = 1'b0, tok = 1'b0, ws = 1'b0, wd = 1'b0, td = 1'b0;
    logic [IVW-1:0] intv = '0;
    logic resp_d, resp_z, flush, wp, tp;
    logic [3:0] bst;

    int checks = 0;
    int fails  = 0;

    int         m_st [2];
    bit         m_wp, m_tp, m_fl, m_tok;
    int         m_arm;
    logic [CW-1:0] m_cnt;

    always #2.5 clk = ~clk;

    iso_tx_flush_ctrl #(.IVW(IVW)) u0 (
        .clk(clk), .rst_n(rst_n), .pipe_en_i(pipe_en), .intv_i(intv),
        .sof_i(sof), .in_tok_i(tok), .wr_start_i(ws), .wr_done_i(wd),
        .tx_done_i(td), .resp_data_o(resp_d), .resp_zlp_o(resp_z),
        .flush_o(flush), .wr_ptr_o(wp), .tx_ptr_o(tp), .bank_st_o(bst)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic mclear();
        m_st[0] = 0; m_st[1] = 0; m_wp = 0; m_tp = 0;
        m_fl = 0; m_tok = 0; m_arm = 0; m_cnt = '0;
    endtask

    task automatic cmp_state(string tag);
        chk(tag, "bank_st", 32'(bst), 32'({m_st[1][1:0], m_st[0][1:0]}));
        chk(tag, "wr_ptr", 32'(wp), 32'(m_wp));
        chk(tag, "tx_ptr", 32'(tp), 32'(m_tp));
        chk(tag, "flush", 32'(flush), 32'(m_fl));
    endtask

    // One cycle: drive at negedge, check responses, step model, check state at next negedge.
    task automatic step(string tag, bit p, bit s, bit t, bit a, bit b, bit c);
        int n [2];
        bit txen, fl, norm, nwp, ntp, ntok;
        int narm;
        logic [CW-1:0] ncnt, mask, cnx;
        pipe_en = p; sof = s; tok = t; ws = a; wd = b; td = c;
        #1;
        txen = (m_st[m_tp] == 3);
        chk("R6", "resp_data", 32'(resp_d), 32'(t && txen));
        chk("R6", "resp_zlp", 32'(resp_z), 32'(t && !txen));
        n[0] = m_st[0]; n[1] = m_st[1];
        nwp = m_wp; ntp = m_tp; narm = m_arm; ncnt = m_cnt; ntok = m_tok;
        mask = ~({CW{1'b1}} << intv);
        cnx  = (m_cnt + CW'(1)) & mask;
        fl   = (m_arm == 2) && s && (m_cnt == '0) && !m_tok && txen;
        norm = c && txen && !fl;
        if (!p) begin
            n[0] = 0; n[1] = 0; nwp = 0; ntp = 0; narm = 0; ncnt = '0; ntok = 0; fl = 0;
        end else begin
            if (a && m_st[m_wp] == 0) n[m_wp] = 1;
            if (b && m_st[m_wp] == 1) begin n[m_wp] = 2; nwp = !m_wp; end
            if (fl || norm) begin n[m_tp] = 0; ntp = !m_tp; end
            for (int i = 0; i < 2; i++)
                if (m_st[i] == 2 && ntp == 1'(i)) n[i] = 3;
            if (m_arm == 0) begin
                narm = 1; ncnt = '0; ntok = 0;
            end else if (m_arm == 1) begin
                if (intv == '0) begin
                    if (s) begin narm = 2; ncnt = '0; ntok = t; end
                end else if (norm) begin
                    narm = 2; ncnt = '0; ntok = 1;
                end
            end else begin
                if (s) begin ncnt = cnx; ntok = t && (cnx == '0); end
                else if (t && m_cnt == '0) ntok = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        m_st[0] = n[0]; m_st[1] = n[1]; m_wp = nwp; m_tp = ntp;
        m_arm = narm; m_cnt = ncnt; m_tok = ntok; m_fl = fl;
        cmp_state(tag);
    endtask

    task automatic idle(string tag, int k);
        for (int i = 0; i < k; i++) step(tag, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic restart(string tag, logic [IVW-1:0] iv);
        step(tag, 0, 0, 0, 0, 0, 0);
        intv = iv;
        step(tag, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(string tag);
        step(tag, 1, 0, 0, 1, 0, 0);
        step(tag, 1, 0, 0, 0, 1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'd1234);
        mclear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "bank_st", 32'(bst), 32'd0);
        chk("R1", "ptrs", 32'({wp, tp}), 32'd0);
        chk("R1", "flush", 32'(flush), 32'd0);

        // R2 R3 R4: fill, ignored starts/dones, promotion
        restart("R2", 2'd0);
        step("R3", 1, 0, 0, 0, 1, 0);          // done while empty: ignored
        step("R2", 1, 0, 0, 1, 0, 0);
        step("R2", 1, 0, 0, 1, 0, 0);          // start while writing: ignored
        step("R3", 1, 0, 0, 0, 1, 0);
        step("R4", 1, 0, 0, 0, 0, 0);
        chk("R4", "bank0 txen", 32'(bst[1:0]), 32'd3);
        // R5: transmit done, then a done with nothing enabled
        step("R5", 1, 0, 1, 0, 0, 1);
        chk("R5", "bank0 emptied", 32'(bst[1:0]), 32'd0);
        step("R5", 1, 0, 1, 0, 0, 1);          // R6 zlp path, R5 ignored done

        // R7: interval 0, enable frame exempt, then flush
        restart("R7", 2'd0);
        fill("R7");
        idle("R7", 1);
        step("R7", 1, 1, 0, 0, 0, 0);          // first SOF arms, no flush
        chk("R7", "no flush at arming", 32'(flush), 32'd0);
        idle("R7", 2);
        step("R9", 1, 1, 0, 0, 0, 0);          // frame without token closes
        chk("R9", "flush pulse", 32'(flush), 32'd1);
        chk("R9", "bank0 empty", 32'(bst[1:0]), 32'd0);
        idle("R9", 1);
        chk("R9", "flush single cycle", 32'(flush), 32'd0);

        // R10: both banks loaded, flush promotes partner
        restart("R10", 2'd0);
        fill("R10"); fill("R10");
        idle("R10", 1);
        step("R10", 1, 1, 0, 0, 0, 0);
        idle("R10", 1);
        step("R10", 1, 1, 0, 0, 0, 0);
        chk("R10", "swap", 32'(bst), 32'h0C);

        // R8: nonzero interval, no flush before a normal transaction
        restart("R8", 2'd2);
        fill("R8");
        idle("R8", 1);
        for (int i = 0; i < 6; i++) begin
            step("R8", 1, 1, 0, 0, 0, 0);
            chk("R8", "no flush unarmed", 32'(flush), 32'd0);
        end
        chk("R8", "bank kept", 32'(bst[1:0]), 32'd3);

        // R11: period 2, early token does not count
        restart("R11", 2'd1);
        fill("R11"); fill("R11");
        idle("R11", 1);
        step("R11", 1, 0, 1, 0, 0, 1);         // normal transaction arms
        step("R11", 1, 1, 0, 0, 0, 0);         // service frame had token
        step("R11", 1, 0, 1, 0, 0, 0);         // early token
        step("R11", 1, 1, 0, 0, 0, 0);         // enter service frame
        step("R11", 1, 1, 0, 0, 0, 0);         // closes without token
        chk("R11", "flush after early token", 32'(flush), 32'd1);

        // R12: flush and transmit done together
        restart("R12", 2'd0);
        fill("R12");
        idle("R12", 1);
        step("R12", 1, 1, 0, 0, 0, 0);
        idle("R12", 1);
        step("R12", 1, 1, 0, 0, 0, 1);
        chk("R12", "flush wins", 32'(flush), 32'd1);
        chk("R12", "bank empty", 32'(bst[1:0]), 32'd0);

        // R13: pipe drop clears
        fill("R13");
        step("R13", 0, 0, 0, 0, 0, 0);
        chk("R13", "cleared", 32'(bst), 32'd0);

        // Mixed random traffic
        for (int i = 0; i < 20000; i++) begin
            bit p;
            p = ($urandom % 400) != 0;
            if (!p) intv = IVW'($urandom % 4);
            step("R9", p, ($urandom % 6) == 0, ($urandom % 9) == 0,
                 ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 5) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule